// File: doc/BRIEF.md
# Multi-Cycle Shared-Resource Processor Datapath

This block is the 32-bit datapath of a small load/store processor. Each instruction runs over several clock cycles. Within those cycles one adder/logic unit and one memory port are reused for different jobs:

- fetching the instruction and advancing the program counter;
- forming a branch target;
- computing an effective address;
- producing an arithmetic result.

Values that must survive from one cycle to the next sit in holding registers: a program counter, an instruction register, a read-data register, two operand registers and a result register. A 32-entry register file completes the state.

The block makes no decisions of its own. An external sequencer drives one set of control strobes per cycle and reads back two things: the 6-bit opcode of the held instruction and the zero flag of the live arithmetic result. From these it steps the instruction through fetch, decode and the class-specific cycles. The instruction classes are register-register arithmetic, word load, word store, branch-on-equal and absolute jump.

The memory port carries no back-pressure. The read and write strobes are copied straight from the sequencer. Read data must be valid in the same cycle the address is presented. A memory that needs more time must hold off the sequencer rather than the datapath.

Top module: `mc_datapath`

## Requirements
- R1: A synchronous reset sets the program counter to 0, clears every holding register and clears all register-file entries.
- R2: With `addr_sel` low, `mem_addr` shows the program counter. With it high, `mem_addr` shows the result register captured in the previous cycle.
- R3: The instruction register loads `mem_rdata` only on a clock edge where `ir_wr` is high, and otherwise keeps its value. `opcode` always shows its bits [31:26].
- R4: The first operand is the program counter when `srca_sel` is 0 and the A register when it is 1. `srcb_sel` picks the second operand as follows: 0 gives the B register, 1 gives the constant 4, 2 gives instruction bits [15:0] sign-extended, and 3 gives that sign-extended value shifted left by two.
- R5: `alu_mode` 0 adds and 1 subtracts. Values 2 and 3 decode the function field in instruction bits [5:0]: 32 is add, 34 is subtract, 36 is bitwise AND, 37 is bitwise OR, and 42 is a signed set-less-than that yields 1 or 0. Any other function code adds.
- R6: `zero` is high exactly when the live arithmetic result of the current cycle is all zeros.
- R7: The program counter is written on an edge where `pc_wr` is high, or where both `pc_wr_cond` and `zero` are high, and it holds otherwise. `pc_src` picks the new value: 0 gives the live result, 1 gives the result register, and 2 or 3 gives the jump target. The jump target is the top four bits of the current program counter, then instruction bits [25:0], then two zero bits.
- R8: The register file reads the entries addressed by instruction bits [25:21] and [20:16]. When `rf_wr` is high it writes on the clock edge. The write goes to bits [20:16] when `dst_sel` is 0 and to bits [15:11] when it is 1. The data written is the result register when `wb_sel` is 0 and the read-data register when it is 1. Entry 0 always reads zero and is never changed.
- R9: `mem_wdata` is the B register, which holds the entry addressed by bits [20:16] as read one cycle earlier. `mem_rd` and `mem_wr` follow `rd_strobe` and `wr_strobe` in the same cycle.
- R10: The A, B, result and read-data registers load new values on every clock edge, with no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pc_wr | input | 1 | Unconditional program-counter write |
| pc_wr_cond | input | 1 | Program-counter write qualified by `zero` |
| ir_wr | input | 1 | Instruction register load enable |
| addr_sel | input | 1 | Memory address source: 0 program counter, 1 result register |
| srca_sel | input | 1 | First operand source: 0 program counter, 1 A register |
| srcb_sel | input | 2 | Second operand source: B, 4, immediate, immediate shifted by two |
| alu_mode | input | 2 | 0 add, 1 subtract, 2 or 3 decode function field |
| dst_sel | input | 1 | Register write address: 0 bits [20:16], 1 bits [15:11] |
| wb_sel | input | 1 | Register write data: 0 result register, 1 read-data register |
| rf_wr | input | 1 | Register file write enable |
| pc_src | input | 2 | Next-PC source: live result, result register, jump target |
| rd_strobe | input | 1 | Memory read request from the sequencer |
| wr_strobe | input | 1 | Memory write request from the sequencer |
| mem_rdata | input | 32 | Memory read data, valid in the same cycle as the address |
| opcode | output | 6 | Instruction register bits [31:26] |
| zero | output | 1 | Live arithmetic result is zero |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data (B register) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |

## Verification
The checks assume the sequencer never raises the read and write strobes together. They also assume it keeps `addr_sel` low in any cycle where the program counter is checked through `mem_addr`. The jump-target check further assumes the upper four bits of the program counter are taken after the fetch cycle has already advanced it. The stimulus meets all of this because a single bench task sequences every instruction exactly as a legal sequencer would. That task raises each strobe only in its proper cycle and fetches only with `addr_sel` low. It places every instruction and operand address inside the modelled memory window.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [2:0] {
    FN_ADD,
    FN_SUB,
    FN_AND,
    FN_OR,
    FN_SLT
  } alu_fn_e;

  localparam logic [5:0] FUNCT_ADD = 6'd32;
  localparam logic [5:0] FUNCT_SUB = 6'd34;
  localparam logic [5:0] FUNCT_AND = 6'd36;
  localparam logic [5:0] FUNCT_OR  = 6'd37;
  localparam logic [5:0] FUNCT_SLT = 6'd42;

  localparam logic [1:0] MODE_ADD = 2'd0;
  localparam logic [1:0] MODE_SUB = 2'd1;

  localparam logic [1:0] SRCB_REG   = 2'd0;
  localparam logic [1:0] SRCB_FOUR  = 2'd1;
  localparam logic [1:0] SRCB_IMM   = 2'd2;
  localparam logic [1:0] SRCB_IMMSH = 2'd3;

  localparam logic [1:0] NPC_LIVE  = 2'd0;
  localparam logic [1:0] NPC_LATCH = 2'd1;

endpackage

// File: rtl/mc_alu_ctl.sv
module mc_alu_ctl
  import mc_pkg::*;
(
  input  logic [1:0] alu_mode,
  input  logic [5:0] funct,
  output alu_fn_e    fn
);

  always_comb begin
    fn = FN_ADD;
    if (alu_mode == MODE_SUB) begin
      fn = FN_SUB;
    end else if (alu_mode[1]) begin
      unique case (funct)
        FUNCT_SUB: fn = FN_SUB;
        FUNCT_AND: fn = FN_AND;
        FUNCT_OR:  fn = FN_OR;
        FUNCT_SLT: fn = FN_SLT;
        default:   fn = FN_ADD;
      endcase
    end
  end

endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  alu_fn_e      fn,
  output logic [W-1:0] res,
  output logic         is_zero
);

  always_comb begin
    unique case (fn)
      FN_SUB:  res = opa - opb;
      FN_AND:  res = opa & opb;
      FN_OR:   res = opa | opb;
      FN_SLT:  res = {{(W-1){1'b0}}, ($signed(opa) < $signed(opb))};
      default: res = opa + opb;
    endcase
  end

  assign is_zero = (res == '0);

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic          we,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);

  logic [W-1:0] ent_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      // entry 0 is never written
      for (int i = 1; i < DEPTH; i++) begin
        if (we && (wa == AW'(i))) ent_q[i] <= wd;
      end
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : ent_q[ra1];
  assign rd2 = (ra2 == '0) ? '0 : ent_q[ra2];

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int REG_CNT = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pc_wr,
  input  logic            pc_wr_cond,
  input  logic            ir_wr,
  input  logic            addr_sel,
  input  logic            srca_sel,
  input  logic [1:0]      srcb_sel,
  input  logic [1:0]      alu_mode,
  input  logic            dst_sel,
  input  logic            wb_sel,
  input  logic            rf_wr,
  input  logic [1:0]      pc_src,
  input  logic            rd_strobe,
  input  logic            wr_strobe,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [5:0]      opcode,
  output logic            zero,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic            mem_rd,
  output logic            mem_wr
);

  localparam int RAW    = $clog2(REG_CNT);
  localparam int IMM_W  = 16;
  localparam int JMP_W  = 26;
  localparam int PCHI_W = XLEN - JMP_W - 2;

  // holding registers
  logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, res_q;

  // combinational nets
  logic [XLEN-1:0] opa, opb, alu_y, imm_ext, imm_sh, jmp_tgt, pc_next;
  logic [XLEN-1:0] rf_rd1, rf_rd2, rf_wd;
  logic [RAW-1:0]  rf_wa;
  logic            pc_en;
  alu_fn_e         fn;

  // instruction fields
  logic [RAW-1:0] f_rs, f_rt, f_rd;
  assign f_rs = ir_q[21 +: RAW];
  assign f_rt = ir_q[16 +: RAW];
  assign f_rd = ir_q[11 +: RAW];

  assign imm_ext = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign imm_sh  = {imm_ext[XLEN-3:0], 2'b00};
  assign jmp_tgt = {pc_q[XLEN-1 -: PCHI_W], ir_q[JMP_W-1:0], 2'b00};

  // operand selection
  assign opa = srca_sel ? a_q : pc_q;

  always_comb begin
    unique case (srcb_sel)
      SRCB_REG:   opb = b_q;
      SRCB_FOUR:  opb = XLEN'(4);
      SRCB_IMM:   opb = imm_ext;
      default:    opb = imm_sh;
    endcase
  end

  mc_alu_ctl u_ctl (
    .alu_mode (alu_mode),
    .funct    (ir_q[5:0]),
    .fn       (fn)
  );

  mc_alu #(.W(XLEN)) u_alu (
    .opa     (opa),
    .opb     (opb),
    .fn      (fn),
    .res     (alu_y),
    .is_zero (zero)
  );

  // next program counter
  always_comb begin
    unique case (pc_src)
      NPC_LIVE:  pc_next = alu_y;
      NPC_LATCH: pc_next = res_q;
      default:   pc_next = jmp_tgt;
    endcase
  end

  assign pc_en = pc_wr | (pc_wr_cond & zero);

  // register file write side
  assign rf_wa = dst_sel ? f_rd : f_rt;
  assign rf_wd = wb_sel ? mdr_q : res_q;

  mc_regfile #(.W(XLEN), .DEPTH(REG_CNT)) u_rf (
    .clk (clk),
    .rst (rst),
    .ra1 (f_rs),
    .ra2 (f_rt),
    .wa  (rf_wa),
    .wd  (rf_wd),
    .we  (rf_wr),
    .rd1 (rf_rd1),
    .rd2 (rf_rd2)
  );

  // state
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ir_q  <= '0;
      mdr_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      res_q <= '0;
    end else begin
      if (pc_en) pc_q <= pc_next;
      if (ir_wr) ir_q <= mem_rdata;
      mdr_q <= mem_rdata;
      a_q   <= rf_rd1;
      b_q   <= rf_rd2;
      res_q <= alu_y;
    end
  end

  // memory side
  assign mem_addr  = addr_sel ? res_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_rd    = rd_strobe;
  assign mem_wr    = wr_strobe;
  assign opcode    = ir_q[XLEN-1 -: 6];

endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            pc_wr,
  input logic            pc_wr_cond,
  input logic            ir_wr,
  input logic            addr_sel,
  input logic [1:0]      pc_src,
  input logic            zero,
  input logic [XLEN-1:0] mem_addr,
  input logic [5:0]      opcode,
  input logic            mem_rd,
  input logic            mem_wr,
  input logic [XLEN-1:0] ir_q,
  input logic [XLEN-1:0] a_q
);

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!pc_wr && !pc_wr_cond && !addr_sel) |=> (addr_sel || $stable(mem_addr))); // R7

  AST_BR_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (!pc_wr && pc_wr_cond && !zero && !addr_sel) |=> (addr_sel || $stable(mem_addr))); // R7

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    (pc_wr && pc_src[1] && !addr_sel) |=>
      (addr_sel || mem_addr == {$past(mem_addr[XLEN-1 -: XLEN-28]), $past(ir_q[25:0]), 2'b00})); // R7

  AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ir_wr |=> $stable(opcode)); // R3

  AST_RS0_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ir_q[25:21] == 5'd0) |=> (a_q == '0)); // R8

  AST_STRB_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R9

endmodule

bind mc_datapath mc_datapath_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/tb_mc_datapath.sv
module tb_mc_datapath;

  localparam int XLEN = 32;
  localparam logic [5:0] OP_R = 6'd0, OP_J = 6'd2, OP_BEQ = 6'd4, OP_LW = 6'd35, OP_SW = 6'd43;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pc_wr, pc_wr_cond, ir_wr, addr_sel, srca_sel, dst_sel, wb_sel, rf_wr;
  logic rd_strobe, wr_strobe;
  logic [1:0] srcb_sel, alu_mode, pc_src;
  logic [XLEN-1:0] mem_rdata, mem_addr, mem_wdata;
  logic [5:0] opcode;
  logic zero, mem_rd, mem_wr;

  always #2 clk = ~clk;

  mc_datapath dut (
    .clk(clk), .rst(rst), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .ir_wr(ir_wr),
    .addr_sel(addr_sel), .srca_sel(srca_sel), .srcb_sel(srcb_sel), .alu_mode(alu_mode),
    .dst_sel(dst_sel), .wb_sel(wb_sel), .rf_wr(rf_wr), .pc_src(pc_src),
    .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .mem_rdata(mem_rdata),
    .opcode(opcode), .zero(zero), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr)
  );

  // word-addressed memory model, 1024 words
  logic [31:0] mem [1024];
  assign mem_rdata = mem[mem_addr[11:2]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[11:2]] <= mem_wdata;

  int n_chk = 0, n_bad = 0;
  logic [31:0] pc_m;
  logic [31:0] rf_m [32];
  int slot = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    pc_wr = 0; pc_wr_cond = 0; ir_wr = 0; addr_sel = 0; srca_sel = 0;
    srcb_sel = 0; alu_mode = 0; dst_sel = 0; wb_sel = 0; rf_wr = 0; pc_src = 0;
    rd_strobe = 0; wr_strobe = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] alu_ref(input logic [5:0] f, input logic [31:0] x, input logic [31:0] y);
    case (f)
      6'd34:   return x - y;
      6'd36:   return x & y;
      6'd37:   return x | y;
      6'd42:   return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      default: return x + y;
    endcase
  endfunction

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] f);
    return {OP_R, 5'(rs), 5'(rt), 5'(rd), 5'd0, f};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  // sequence one instruction the way a legal sequencer would, updating the model
  task automatic run(input logic [31:0] w, input string req);
    logic [31:0] ea, simm;
    int rs, rt, rd;
    rs = int'(w[25:21]); rt = int'(w[20:16]); rd = int'(w[15:11]);
    simm = {{16{w[15]}}, w[15:0]};
    mem[pc_m[11:2]] = w;
    idle();
    addr_sel = 0; rd_strobe = 1; ir_wr = 1; srcb_sel = 2'd1; pc_wr = 1; pc_src = 0;
    #1;
    chk(mem_addr == pc_m, {"R2 R7 fetch address ", req}, mem_addr, pc_m);
    step();
    pc_m = pc_m + 32'd4;
    chk(opcode == w[31:26], {"R3 opcode ", req}, {26'd0, opcode}, {26'd0, w[31:26]});
    idle(); srcb_sel = 2'd3; step();
    case (w[31:26])
      OP_R: begin
        idle(); srca_sel = 1; alu_mode = 2'd2; step();
        idle(); dst_sel = 1; rf_wr = 1; step();
        if (rd != 0) rf_m[rd] = alu_ref(w[5:0], rf_m[rs], rf_m[rt]);
      end
      OP_LW: begin
        ea = rf_m[rs] + simm;
        idle(); srca_sel = 1; srcb_sel = 2'd2; step();
        idle(); addr_sel = 1; rd_strobe = 1; #1;
        chk(mem_addr == ea && mem_rd && !mem_wr, {"R2 R9 load address ", req}, mem_addr, ea);
        step();
        idle(); wb_sel = 1; rf_wr = 1; step();
        if (rt != 0) rf_m[rt] = mem[ea[11:2]];
      end
      OP_SW: begin
        ea = rf_m[rs] + simm;
        idle(); srca_sel = 1; srcb_sel = 2'd2; step();
        idle(); addr_sel = 1; wr_strobe = 1; #1;
        chk(mem_addr == ea && mem_wr && !mem_rd, {"R2 R9 store address ", req}, mem_addr, ea);
        chk(mem_wdata == rf_m[rt], {"R9 store data ", req}, mem_wdata, rf_m[rt]);
        step();
      end
      OP_BEQ: begin
        idle(); srca_sel = 1; alu_mode = 2'd1; pc_wr_cond = 1; pc_src = 2'd1; #1;
        chk(zero == (rf_m[rs] == rf_m[rt]), {"R6 zero flag ", req}, {31'd0, zero},
            {31'd0, rf_m[rs] == rf_m[rt]});
        step();
        if (rf_m[rs] == rf_m[rt]) pc_m = pc_m + {simm[29:0], 2'b00};
      end
      OP_J: begin
        idle(); pc_wr = 1; pc_src = 2'd2; step();
        pc_m = {pc_m[31:28], w[25:0], 2'b00};
      end
      default: ;
    endcase
    idle();
  endtask

  // store register r to a check slot and compare with the model
  task automatic check_reg(input int r, input string req);
    logic [31:0] a;
    a = 32'hF00 + 32'(slot * 4);
    slot = (slot + 1) % 32;
    run(enc_i(OP_SW, 0, r, a[15:0]), req);
    chk(mem[a[11:2]] == rf_m[r], req, mem[a[11:2]], rf_m[r]);
  endtask

  logic [31:0] vals [6];
  bit done = 0;

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    for (int i = 0; i < 1024; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
    for (int i = 0; i < 32; i++) rf_m[i] = '0;
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'h7FFF_FFFF;
    vals[3] = 32'h8000_0000; vals[4] = 32'hFFFF_FFFF; vals[5] = 32'h1234_5678;
    for (int i = 0; i < 6; i++) mem[1000 + i] = vals[i];
    mem[1010] = 32'h0000_0F80;
    pc_m = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: program counter starts at zero
    chk(mem_addr == 32'd0, "R1 reset program counter", mem_addr, 32'd0);
    @(negedge clk);
    chk(mem_addr == 32'd0, "R1 program counter holds with no write", mem_addr, 32'd0);
    // R1: registers read zero after reset
    check_reg(7, "R1 register cleared by reset");
    check_reg(31, "R1 register cleared by reset");

    // R8: load operands into r1..r6 (rt destination)
    for (int i = 0; i < 6; i++) begin
      run(enc_i(OP_LW, 0, i + 1, 16'(32'hFA0 + 32'(i * 4))), "R8 load");
      check_reg(i + 1, "R8 load write-back via rt");
    end

    // R5 R4 R10: sweep all function codes over all operand pairs
    begin
      logic [5:0] fl [6];
      fl[0] = 6'd32; fl[1] = 6'd34; fl[2] = 6'd36; fl[3] = 6'd37; fl[4] = 6'd42; fl[5] = 6'd0;
      for (int f = 0; f < 6; f++)
        for (int x = 1; x <= 6; x++)
          for (int y = 1; y <= 6; y++) begin
            run(enc_r(x, y, 12, fl[f]), "R5 arithmetic");
            check_reg(12, "R5 R8 R10 result via rd");
          end
    end

    // R8: entry 0 ignores writes
    run(enc_r(5, 5, 0, 6'd32), "R8 write to entry 0");
    check_reg(0, "R8 entry 0 after arithmetic write");
    run(enc_i(OP_LW, 0, 0, 16'hFA4), "R8 load to entry 0");
    check_reg(0, "R8 entry 0 after load");

    // R4: negative immediate with nonzero base (base 0xF80, offset -16)
    run(enc_i(OP_LW, 0, 20, 16'hFC8), "R4 base load");
    run(enc_i(OP_SW, 20, 6, 16'hFFF0), "R4 negative offset store");
    chk(mem[(32'hF70) >> 2] == rf_m[6], "R4 negative offset store target", mem[(32'hF70) >> 2], rf_m[6]);
    run(enc_i(OP_LW, 20, 21, 16'hFFF0), "R4 negative offset load");
    check_reg(21, "R4 negative offset load value");

    // R7 R6: branch taken forward, taken backward, not taken
    run(enc_i(OP_BEQ, 1, 1, 16'd3), "R7 taken forward");
    run(enc_i(OP_BEQ, 2, 2, 16'hFFFE), "R7 taken backward");
    run(enc_i(OP_BEQ, 1, 2, 16'd5), "R7 not taken");
    run(enc_i(OP_BEQ, 4, 5, 16'd7), "R7 not taken");
    run(enc_i(OP_BEQ, 0, 1, 16'd2), "R7 equal zero operand");
    run(enc_r(1, 1, 13, 6'd32), "R7 after branches");

    // R7: absolute jumps
    run({OP_J, 26'(((pc_m + 32'd40) >> 2))}, "R7 jump forward");
    run({OP_J, 26'(((pc_m - 32'd16) >> 2))}, "R7 jump backward");
    run(enc_r(2, 3, 14, 6'd42), "R7 after jumps");
    check_reg(14, "R5 slt after jumps");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule